// File: doc/BRIEF.md
# Packed Signed Lane Adder with Sign Flags

This block adds two 32-bit words as packed signed lanes. A mode input picks the lane layout: two 16-bit lanes or four 8-bit lanes. Each lane result is the sum of that lane alone, wrapped to the lane width. No carry crosses from one lane into the next. A 4-bit flag vector reports, for each lane, whether the exact signed sum is zero or positive. The flag comes from a sum one bit wider than the lane, not from the wrapped result, so it stays correct when a lane overflows.

The datapath is built from four byte slices. A carry path joins slice pairs in halfword mode and is cut in byte mode. A flag mapper turns the slice sign bits into the flag vector. One output register stage holds the packed result and the flags. The register loads only when the enable input is high, which is how a caller models a failed condition.

The output stage has two named states. ST_EMPTY follows reset, before any load. ST_LOADED holds a captured result. There are two transitions. T_CAPTURE (enable high) moves the stage to ST_LOADED, or keeps it there, and loads new data. T_KEEP (enable low) leaves the state and the data unchanged.

Top module: `sadd_lane_unit`

## Requirements
- R1: While rst_ni is low, and after reset until the first enabled cycle, sum_o reads 0x00000000 and ge_o reads 4'b0000.
- R2: With mode_i = 0 (halfword mode), sum_o[15:0] is (a_i[15:0] + b_i[15:0]) mod 2^16 and sum_o[31:16] is (a_i[31:16] + b_i[31:16]) mod 2^16. A carry out of bit 15 never reaches bit 16.
- R3: With mode_i = 1 (byte mode), each byte k of sum_o (bits 8k+7:8k, k = 0..3) is (a_i byte k + b_i byte k) mod 256, with no carry between bytes.
- R4: A lane flag is 1 exactly when the signed sum of that lane, taken at full precision, is >= 0. Examples: in byte mode 0x7F + 0x01 gives result 0x80 with flag 1, and 0x80 + 0x80 gives 0x00 with flag 0.
- R5: In halfword mode, ge_o[1] and ge_o[0] both equal the flag of the low halfword, and ge_o[3] and ge_o[2] both equal the flag of the high halfword.
- R6: In byte mode, ge_o[k] is the flag of byte lane k, with bit 0 belonging to the least significant byte.
- R7: When en_i is low at a rising clock edge, sum_o and ge_o keep the values they had before that edge.
- R8: When en_i is high at a rising edge, sum_o and ge_o show the result for the a_i, b_i and mode_i sampled at that edge, right after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| mode_i | input | 1 | Lane layout: 0 = two halfwords, 1 = four bytes |
| en_i | input | 1 | Update enable (condition passed) |
| sum_o | output | 32 | Registered packed lane sums |
| ge_o | output | 4 | Registered per-lane sign flags |

## Verification
The hardest cases to reach are those where the wrapped result and the full-precision sign disagree. They only happen when both operands of a lane have the same sign and the sum overflows. The bench drives these cases on purpose: most-positive plus one, most-negative plus most-negative, and exact zero sums such as -1 + 1. It drives them in both modes and puts different patterns in neighbouring lanes, so that a flag taken from the wrong lane or a carry leaking across a lane boundary changes the outcome. Hold cycles with en_i low come between loads that carry different operands, so a missed hold shows up on the outputs.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
    localparam int SLICE_W    = 8;
    localparam int NUM_SLICES = 4;
    localparam int DATA_W     = SLICE_W * NUM_SLICES;

    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_BYTE = 1'b1
    } lane_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_e;
endpackage

// File: rtl/sadd_byte_slice.sv
module sadd_byte_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ext_sign_o
);
    logic [W:0] usum;
    logic [W:0] ssum;

    always_comb begin
        // unsigned add gives the carry for the next slice
        usum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        // sign-extended add gives the sign of the full-precision sum
        ssum = {a_i[W-1], a_i} + {b_i[W-1], b_i} + {{W{1'b0}}, cin_i};
        res_o      = usum[W-1:0];
        cout_o     = usum[W];
        ext_sign_o = ssum[W];
    end
endmodule

// File: rtl/sadd_carry_chain.sv
module sadd_carry_chain
    import sadd_pkg::*;
#(
    parameter int W = SLICE_W,
    parameter int N = NUM_SLICES
) (
    input  logic [W*N-1:0] a_i,
    input  logic [W*N-1:0] b_i,
    input  lane_mode_e     mode_i,
    output logic [W*N-1:0] sum_o,
    output logic [N-1:0]   sign_o
);
    logic [N-1:0] cout;
    logic [N-1:0] cin;

    for (genvar i = 0; i < N; i++) begin : g_slice
        if (i % 2 == 1) begin : g_upper
            // joined to the slice below only in halfword mode
            assign cin[i] = (mode_i == MODE_HALF) ? cout[i-1] : 1'b0;
        end else begin : g_lower
            assign cin[i] = 1'b0;
        end

        sadd_byte_slice #(.W(W)) u_slice (
            .a_i        (a_i[i*W +: W]),
            .b_i        (b_i[i*W +: W]),
            .cin_i      (cin[i]),
            .res_o      (sum_o[i*W +: W]),
            .cout_o     (cout[i]),
            .ext_sign_o (sign_o[i])
        );
    end
endmodule

// File: rtl/sadd_flag_map.sv
module sadd_flag_map
    import sadd_pkg::*;
#(
    parameter int N = NUM_SLICES
) (
    input  logic [N-1:0] sign_i,
    input  lane_mode_e   mode_i,
    output logic [N-1:0] ge_o
);
    localparam int PAIRS = N / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // in halfword mode the upper slice of a pair carries the lane sign
        always_comb begin
            unique case (mode_i)
                MODE_HALF: ge_o[2*p +: 2] = {2{~sign_i[2*p+1]}};
                MODE_BYTE: ge_o[2*p +: 2] = ~sign_i[2*p +: 2];
                default:   ge_o[2*p +: 2] = '0;
            endcase
        end
    end
endmodule

// File: rtl/sadd_lane_unit.sv
module sadd_lane_unit
    import sadd_pkg::*;
#(
    parameter int LANE_W = SLICE_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [4*LANE_W-1:0]    a_i,
    input  logic [4*LANE_W-1:0]    b_i,
    input  logic                   mode_i,
    input  logic                   en_i,
    output logic [4*LANE_W-1:0]    sum_o,
    output logic [3:0]             ge_o
);
    localparam int N  = 4;
    localparam int DW = N * LANE_W;

    lane_mode_e    mode;
    logic [DW-1:0] sum_c;
    logic [N-1:0]  sign_c;
    logic [N-1:0]  ge_c;
    out_state_e    state_q, state_d;
    logic [DW-1:0] sum_q;
    logic [N-1:0]  ge_q;

    assign mode = lane_mode_e'(mode_i);

    sadd_carry_chain #(.W(LANE_W), .N(N)) u_chain (
        .a_i    (a_i),
        .b_i    (b_i),
        .mode_i (mode),
        .sum_o  (sum_c),
        .sign_o (sign_c)
    );

    sadd_flag_map #(.N(N)) u_flags (
        .sign_i (sign_c),
        .mode_i (mode),
        .ge_o   (ge_c)
    );

    // next state: T_CAPTURE on enable, T_KEEP otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (en_i) state_d = ST_LOADED;
            ST_LOADED: state_d = ST_LOADED;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_EMPTY;
        else         state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sum_q <= '0;
            ge_q  <= '0;
        end else if (en_i) begin
            sum_q <= sum_c;
            ge_q  <= ge_c;
        end
    end

    assign sum_o = sum_q;
    assign ge_o  = ge_q;

    a_r1_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_EMPTY) |-> (sum_o == '0 && ge_o == '0));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(sum_o) && $stable(ge_o)));

    a_r5_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !mode_i) |=> (ge_o[0] == ge_o[1] && ge_o[2] == ge_o[3]));

    a_r3_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && mode_i) |=>
        (sum_o[2*LANE_W-1:LANE_W] ==
         LANE_W'($past(a_i[2*LANE_W-1:LANE_W]) + $past(b_i[2*LANE_W-1:LANE_W]))));

    a_r4_same_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && mode_i && a_i[LANE_W-1] == b_i[LANE_W-1]) |=>
        (ge_o[0] == !$past(a_i[LANE_W-1])));

    a_r2_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !mode_i) |=>
        (sum_o[2*LANE_W-1:0] ==
         (2*LANE_W)'($past(a_i[2*LANE_W-1:0]) + $past(b_i[2*LANE_W-1:0]))));
endmodule

// File: tb/sadd_lane_unit_test.sv
module sadd_lane_unit_test;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        mode_i = 1'b0;
    logic        en_i = 1'b0;
    logic [31:0] sum_o;
    logic [3:0]  ge_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_sum_q[$];
    logic [3:0]  exp_ge_q[$];
    string       exp_tag_q[$];
    logic [31:0] last_sum = '0;
    logic [3:0]  last_ge = '0;

    always #5 clk = ~clk;

    sadd_lane_unit uut (
        .clk_i  (clk),
        .rst_ni (rst_ni),
        .a_i    (a_i),
        .b_i    (b_i),
        .mode_i (mode_i),
        .en_i   (en_i),
        .sum_o  (sum_o),
        .ge_o   (ge_o)
    );

    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic m,
                         output logic [31:0] s, output logic [3:0] g);
        if (!m) begin
            for (int h = 0; h < 2; h++) begin
                int t;
                t = int'($signed(a[h*16 +: 16])) + int'($signed(b[h*16 +: 16]));
                s[h*16 +: 16] = t[15:0];
                g[h*2 +: 2] = (t >= 0) ? 2'b11 : 2'b00;
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                int t;
                t = int'($signed(a[k*8 +: 8])) + int'($signed(b[k*8 +: 8]));
                s[k*8 +: 8] = t[7:0];
                g[k] = (t >= 0);
            end
        end
    endtask

    // driver: applies one cycle of stimulus and queues what should follow
    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic m, input logic en, input string tag);
        logic [31:0] s;
        logic [3:0]  g;
        @(negedge clk);
        a_i = a; b_i = b; mode_i = m; en_i = en;
        if (en) begin
            model(a, b, m, s, g);
            last_sum = s;
            last_ge = g;
        end
        exp_sum_q.push_back(last_sum);
        exp_ge_q.push_back(last_ge);
        exp_tag_q.push_back(tag);
    endtask

    // monitor: compares after each edge once stimulus is flowing
    initial begin
        @(posedge rst_ni);
        forever begin
            @(posedge clk);
            #2;
            if (exp_sum_q.size() > 0) begin
                logic [31:0] es;
                logic [3:0]  eg;
                string       et;
                es = exp_sum_q.pop_front();
                eg = exp_ge_q.pop_front();
                et = exp_tag_q.pop_front();
                checks++;
                if (sum_o !== es || ge_o !== eg) begin
                    failures++;
                    $display("FAIL %s: sum=%h ge=%b expected sum=%h ge=%b",
                             et, sum_o, ge_o, es, eg);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (sum_o !== 32'h0 || ge_o !== 4'h0) begin
            failures++;
            $display("FAIL R1: sum=%h ge=%b expected sum=00000000 ge=0000", sum_o, ge_o);
        end
        @(negedge clk);
        rst_ni = 1'b1;
        // R1: idle cycle with enable low keeps reset values
        drive(32'h1234_5678, 32'h1111_1111, 1'b1, 1'b0, "R1");

        // R2 halfword: carry out of low half must not enter high half
        drive(32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b1, "R2");
        drive(32'h1234_8000, 32'h4321_8000, 1'b0, 1'b1, "R2/R4");
        drive(32'h7FFF_0005, 32'h0001_FFFB, 1'b0, 1'b1, "R4/R5");
        drive(32'h8000_7FFF, 32'hFFFF_0001, 1'b0, 1'b1, "R5");
        // R3 byte mode
        drive(32'h7F7F_7F7F, 32'h0101_0101, 1'b1, 1'b1, "R3/R4");
        drive(32'h8080_8080, 32'h8080_8080, 1'b1, 1'b1, "R4");
        drive(32'hFF01_80FF, 32'h01FF_7F01, 1'b1, 1'b1, "R3");
        drive(32'h7F80_00FF, 32'h0180_0002, 1'b1, 1'b1, "R6");
        drive(32'h0000_00FF, 32'h0000_0001, 1'b1, 1'b1, "R3 no carry");
        // R7 hold between different loads
        drive(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0, "R7");
        drive(32'h0101_0101, 32'h0101_0101, 1'b1, 1'b0, "R7");
        // R8 back-to-back loads with mode switch
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R8");
        drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, "R8");

        for (int i = 0; i < 400; i++) begin
            drive($urandom, $urandom, 1'($urandom), ($urandom % 4) != 0,
                  "R2/R3/R6/R7 random");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule